// File: doc/BRIEF.md
# Floating-Point State Restore Sequencer

This block reloads the whole context of a stack-based floating-point unit from a byte image in memory. A one-cycle start pulse carries the base address of the image, the operand size (16 or 32 bit), the current privilege level, a virtual-8086 flag, and the alignment-check, emulate, task-switched and lock-prefix flags. The block then fetches the image one byte at a time over a simple request/response port and builds the new context in shadow registers.

The image opens with an environment area of seven equal slots: 2 bytes each in the 16-bit layout and 4 bytes each in the 32-bit layout. After it come eight 80-bit stack registers of 10 bytes each. The new context appears on the outputs in a single cycle, together with a done pulse. Before any memory access, the request is screened for traps. A trapped request reports a fault code with the done pulse, performs no reads and leaves the context as it was. When a restore completes, the block raises a floating-point exception flag if the new status word holds an exception that the new control word leaves unmasked.

Top module: `fprs_restore`

## Requirements
- R1: A restore reads exactly 94 bytes (16-bit layout) or 108 bytes (32-bit layout) at consecutive addresses, from the base address upward.
- R2: Environment slot k starts at base + k*S, where S is 2 (16-bit) or 4 (32-bit). Slots 0..5 hold, in this order, the control word, status word, tag word, data pointer, instruction pointer and last opcode. Slot 6 is read and discarded. Values are little-endian. The word fields and the opcode take the first two bytes of their slot. The pointers take the whole slot and are zero-extended in the 16-bit layout.
- R3: Stack register k (0..7) is the 10 bytes at base + 7*S + 10*k, least significant byte first, and appears on stack_o bits [80*k +: 80].
- R4: cond_o gives the condition bits of the restored status word: cond_o = {stat[14], stat[10], stat[9], stat[8]} (C3, C2, C1, C0).
- R5: fp_exc_o pulses together with the completion done pulse, and only then, when (stat[5:0] & ~ctrl[5:0]) of the restored words is nonzero.
- R6: If the emulate or task-switched flag is set, the block reports fault code 2 (device not available) one cycle after start, with no memory request.
- R7: If the lock flag is set, the block reports fault code 1 (undefined opcode) one cycle after start, with no memory request. This fault takes precedence over every other fault.
- R8: Fault code 3 (alignment) is reported with no memory request when alignment checking is on, the base is misaligned (base[0] set in the 16-bit layout, base[1:0] nonzero in the 32-bit layout), and either the privilege level is 3 or the virtual-8086 flag is set. It has the lowest fault priority.
- R9: The context outputs change only in the cycle where done_o rises on a completed restore. A faulted request leaves them unchanged.
- R10: mem_req_o is a one-cycle pulse, and the next one comes only after the response strobe for the previous one.
- R11: A start pulse while busy_o is high is ignored: the running restore is unaffected and no extra done pulse follows.
- R12: After reset, busy_o, done_o, fault_o, fp_exc_o, mem_req_o and all context outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| base_addr_i | input | ADDR_W | Base byte address of the image |
| op32_i | input | 1 | 1: 32-bit layout, 0: 16-bit layout |
| cpl_i | input | 2 | Current privilege level |
| v86_i | input | 1 | Virtual-8086 mode flag |
| align_chk_i | input | 1 | Alignment checking enabled |
| emul_i | input | 1 | Emulate flag |
| task_sw_i | input | 1 | Task-switched flag |
| lock_i | input | 1 | Lock prefix present |
| mem_req_o | output | 1 | Byte read request pulse |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_rvalid_i | input | 1 | Read response strobe |
| mem_rdata_i | input | 8 | Read response byte |
| busy_o | output | 1 | Sequencer active |
| done_o | output | 1 | Completion or fault pulse |
| fault_o | output | 2 | Fault code, valid with done_o (0 none, 1 undefined opcode, 2 device not available, 3 alignment) |
| fp_exc_o | output | 1 | Unmasked floating-point exception after restore |
| ctrl_o | output | 16 | Control word |
| stat_o | output | 16 | Status word |
| tag_o | output | 16 | Tag word |
| dptr_o | output | 32 | Data pointer |
| iptr_o | output | 32 | Instruction pointer |
| opc_o | output | 16 | Last opcode |
| cond_o | output | 4 | Condition bits C3..C0 |
| stack_o | output | N_REGS*REG_BYTES*8 | Stack registers, register 0 in the low bits |

## Verification
The assertions assume the memory side never raises mem_rvalid_i unless a request is pending. They also assume that the start sideband (op32_i and the trap flags) is valid in the cycle start_i is accepted, since the read count and the fault codes are judged against the values latched then. The bench's memory model answers each request exactly once, after a chosen latency that may be zero. It drives all start inputs together with the pulse at the falling edge. The one start deliberately sent during a busy restore carries the lock flag, so accepting it by mistake would show up as a wrong fault code or an extra done pulse.

// File: rtl/fprs_pkg.sv
package fprs_pkg;
   localparam int ENV_SLOTS = 7;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_UD   = 2'd1,
      FLT_NM   = 2'd2,
      FLT_AC   = 2'd3
   } fprs_fault_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE  = 2'd1,
      ST_WAIT   = 2'd2,
      ST_COMMIT = 2'd3
   } fprs_state_e;
endpackage

// File: rtl/fprs_screen.sv
module fprs_screen
   import fprs_pkg::*;
(
   input  logic        lock_i,
   input  logic        emul_i,
   input  logic        task_sw_i,
   input  logic        align_chk_i,
   input  logic        v86_i,
   input  logic [1:0]  cpl_i,
   input  logic        op32_i,
   input  logic [1:0]  base_lo_i,
   output fprs_fault_e fault_o
);
   logic misaligned;
   logic ac_trap;

   assign misaligned = op32_i ? (base_lo_i != 2'b00) : base_lo_i[0];
   assign ac_trap    = align_chk_i && misaligned && (v86_i || (cpl_i == 2'd3));

   always_comb begin
      if (lock_i)                 fault_o = FLT_UD;
      else if (emul_i || task_sw_i) fault_o = FLT_NM;
      else if (ac_trap)           fault_o = FLT_AC;
      else                        fault_o = FLT_NONE;
   end
endmodule

// File: rtl/fprs_walker.sv
module fprs_walker #(
   parameter int ADDR_W    = 32,
   parameter int N_REGS    = 8,
   parameter int REG_BYTES = 10,
   parameter int ENV_SLOTS = 7,
   localparam int IDX_W    = $clog2(4*ENV_SLOTS + N_REGS*REG_BYTES + 1),
   localparam int SLOT_W   = $clog2(ENV_SLOTS),
   localparam int RIDX_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1,
   localparam int RB_W     = $clog2(REG_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              op32_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              in_stack_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [1:0]        sbyte_o,
   output logic [RIDX_W-1:0] reg_o,
   output logic [RB_W-1:0]   rbyte_o,
   output logic              last_o
);
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;
   logic              op32_q;
   logic              stk_q;
   logic [SLOT_W-1:0] slot_q;
   logic [1:0]        sbyte_q;
   logic [RIDX_W-1:0] reg_q;
   logic [RB_W-1:0]   rbyte_q;
   logic [1:0]        sbyte_max;

   assign sbyte_max  = op32_q ? 2'd3 : 2'd1;
   assign addr_o     = base_q + ADDR_W'(idx_q);
   assign in_stack_o = stk_q;
   assign slot_o     = slot_q;
   assign sbyte_o    = sbyte_q;
   assign reg_o      = reg_q;
   assign rbyte_o    = rbyte_q;
   assign last_o     = stk_q && (reg_q == RIDX_W'(N_REGS-1)) && (rbyte_q == RB_W'(REG_BYTES-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         idx_q   <= '0;
         op32_q  <= 1'b0;
         stk_q   <= 1'b0;
         slot_q  <= '0;
         sbyte_q <= '0;
         reg_q   <= '0;
         rbyte_q <= '0;
      end else if (load_i) begin
         base_q  <= base_i;
         op32_q  <= op32_i;
         idx_q   <= '0;
         stk_q   <= 1'b0;
         slot_q  <= '0;
         sbyte_q <= '0;
         reg_q   <= '0;
         rbyte_q <= '0;
      end else if (adv_i) begin
         idx_q <= idx_q + 1'b1;
         if (!stk_q) begin
            if (sbyte_q == sbyte_max) begin
               sbyte_q <= '0;
               if (slot_q == SLOT_W'(ENV_SLOTS-1)) stk_q  <= 1'b1;
               else                                slot_q <= slot_q + 1'b1;
            end else begin
               sbyte_q <= sbyte_q + 1'b1;
            end
         end else begin
            if (rbyte_q == RB_W'(REG_BYTES-1)) begin
               rbyte_q <= '0;
               reg_q   <= reg_q + 1'b1;
            end else begin
               rbyte_q <= rbyte_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fprs_shadow.sv
module fprs_shadow #(
   parameter int N_REGS    = 8,
   parameter int REG_BYTES = 10,
   parameter int ENV_SLOTS = 7,
   localparam int REG_W    = REG_BYTES*8,
   localparam int SLOT_W   = $clog2(ENV_SLOTS),
   localparam int RIDX_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1,
   localparam int RB_W     = $clog2(REG_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear_i,
   input  logic                    wr_i,
   input  logic                    in_stack_i,
   input  logic [SLOT_W-1:0]       slot_i,
   input  logic [1:0]              sbyte_i,
   input  logic [RIDX_W-1:0]       reg_i,
   input  logic [RB_W-1:0]         rbyte_i,
   input  logic [7:0]              data_i,
   output logic [15:0]             ctrl_o,
   output logic [15:0]             stat_o,
   output logic [15:0]             tag_o,
   output logic [31:0]             dptr_o,
   output logic [31:0]             iptr_o,
   output logic [15:0]             opc_o,
   output logic [N_REGS*REG_W-1:0] stk_o
);
   logic env_wr;
   logic lo_half;
   logic [3:0] wsel16;
   logic [4:0] wsel32;

   assign env_wr  = wr_i && !in_stack_i;
   assign lo_half = !sbyte_i[1];
   assign wsel16  = {sbyte_i[0], 3'b000};
   assign wsel32  = {sbyte_i, 3'b000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
         stat_o <= '0;
         tag_o  <= '0;
         dptr_o <= '0;
         iptr_o <= '0;
         opc_o  <= '0;
      end else if (clear_i) begin
         ctrl_o <= '0;
         stat_o <= '0;
         tag_o  <= '0;
         dptr_o <= '0;
         iptr_o <= '0;
         opc_o  <= '0;
      end else if (env_wr) begin
         case (slot_i)
            SLOT_W'(0): if (lo_half) ctrl_o[wsel16 +: 8] <= data_i;
            SLOT_W'(1): if (lo_half) stat_o[wsel16 +: 8] <= data_i;
            SLOT_W'(2): if (lo_half) tag_o[wsel16 +: 8]  <= data_i;
            SLOT_W'(3): dptr_o[wsel32 +: 8] <= data_i;
            SLOT_W'(4): iptr_o[wsel32 +: 8] <= data_i;
            SLOT_W'(5): if (lo_half) opc_o[wsel16 +: 8]  <= data_i;
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < N_REGS; g++) begin : g_stk
      logic [REG_W-1:0] reg_q;
      logic [$clog2(REG_W)-1:0] bsel;
      assign bsel = {rbyte_i, 3'b000};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_q <= '0;
         else if (clear_i)
            reg_q <= '0;
         else if (wr_i && in_stack_i && (reg_i == RIDX_W'(g)))
            reg_q[bsel +: 8] <= data_i;
      end
      assign stk_o[g*REG_W +: REG_W] = reg_q;
   end
endmodule

// File: rtl/fprs_restore.sv
module fprs_restore
   import fprs_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_REGS    = 8,
   parameter int REG_BYTES = 10,
   localparam int REG_W    = REG_BYTES*8,
   localparam int STK_W    = N_REGS*REG_W,
   localparam int SLOT_W   = $clog2(ENV_SLOTS),
   localparam int RIDX_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1,
   localparam int RB_W     = $clog2(REG_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic              op32_i,
   input  logic [1:0]        cpl_i,
   input  logic              v86_i,
   input  logic              align_chk_i,
   input  logic              emul_i,
   input  logic              task_sw_i,
   input  logic              lock_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [7:0]        mem_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        fault_o,
   output logic              fp_exc_o,
   output logic [15:0]       ctrl_o,
   output logic [15:0]       stat_o,
   output logic [15:0]       tag_o,
   output logic [31:0]       dptr_o,
   output logic [31:0]       iptr_o,
   output logic [15:0]       opc_o,
   output logic [3:0]        cond_o,
   output logic [STK_W-1:0]  stack_o
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("fprs_restore: ADDR_W must be at least 8");
   end
   if (N_REGS < 1 || N_REGS > 16) begin : g_bad_regs
      $error("fprs_restore: N_REGS out of range");
   end
   if (REG_BYTES < 2 || REG_BYTES > 16) begin : g_bad_rbytes
      $error("fprs_restore: REG_BYTES out of range");
   end

   fprs_state_e state_q;
   fprs_fault_e scr_fault;
   fprs_fault_e fault_q;
   logic        done_q;
   logic        exc_q;
   logic        accept;
   logic        load;
   logic        take;

   logic              in_stack;
   logic [SLOT_W-1:0] slot;
   logic [1:0]        sbyte;
   logic [RIDX_W-1:0] ridx;
   logic [RB_W-1:0]   rbyte;
   logic              last_byte;

   logic [15:0]      sh_ctrl, sh_stat, sh_tag, sh_opc;
   logic [31:0]      sh_dptr, sh_iptr;
   logic [STK_W-1:0] sh_stk;

   logic [15:0]      ctrl_q, stat_q, tag_q, opc_q;
   logic [31:0]      dptr_q, iptr_q;
   logic [STK_W-1:0] stk_q;

   fprs_screen u_screen (
      .lock_i      (lock_i),
      .emul_i      (emul_i),
      .task_sw_i   (task_sw_i),
      .align_chk_i (align_chk_i),
      .v86_i       (v86_i),
      .cpl_i       (cpl_i),
      .op32_i      (op32_i),
      .base_lo_i   (base_addr_i[1:0]),
      .fault_o     (scr_fault)
   );

   assign accept = (state_q == ST_IDLE) && start_i;
   assign load   = accept && (scr_fault == FLT_NONE);
   assign take   = (state_q == ST_WAIT) && mem_rvalid_i;

   fprs_walker #(
      .ADDR_W    (ADDR_W),
      .N_REGS    (N_REGS),
      .REG_BYTES (REG_BYTES),
      .ENV_SLOTS (ENV_SLOTS)
   ) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .base_i     (base_addr_i),
      .op32_i     (op32_i),
      .adv_i      (take),
      .addr_o     (mem_addr_o),
      .in_stack_o (in_stack),
      .slot_o     (slot),
      .sbyte_o    (sbyte),
      .reg_o      (ridx),
      .rbyte_o    (rbyte),
      .last_o     (last_byte)
   );

   fprs_shadow #(
      .N_REGS    (N_REGS),
      .REG_BYTES (REG_BYTES),
      .ENV_SLOTS (ENV_SLOTS)
   ) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (load),
      .wr_i       (take),
      .in_stack_i (in_stack),
      .slot_i     (slot),
      .sbyte_i    (sbyte),
      .reg_i      (ridx),
      .rbyte_i    (rbyte),
      .data_i     (mem_rdata_i),
      .ctrl_o     (sh_ctrl),
      .stat_o     (sh_stat),
      .tag_o      (sh_tag),
      .dptr_o     (sh_dptr),
      .iptr_o     (sh_iptr),
      .opc_o      (sh_opc),
      .stk_o      (sh_stk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         fault_q <= FLT_NONE;
         exc_q   <= 1'b0;
         ctrl_q  <= '0;
         stat_q  <= '0;
         tag_q   <= '0;
         dptr_q  <= '0;
         iptr_q  <= '0;
         opc_q   <= '0;
         stk_q   <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= FLT_NONE;
         exc_q   <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (scr_fault != FLT_NONE) begin
                     done_q  <= 1'b1;
                     fault_q <= scr_fault;
                  end else begin
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rvalid_i) state_q <= last_byte ? ST_COMMIT : ST_ISSUE;
            end
            ST_COMMIT: begin
               ctrl_q  <= sh_ctrl;
               stat_q  <= sh_stat;
               tag_q   <= sh_tag;
               dptr_q  <= sh_dptr;
               iptr_q  <= sh_iptr;
               opc_q   <= sh_opc;
               stk_q   <= sh_stk;
               done_q  <= 1'b1;
               exc_q   <= |(sh_stat[5:0] & ~sh_ctrl[5:0]);
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o = (state_q == ST_ISSUE);
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign fault_o   = fault_q;
   assign fp_exc_o  = exc_q;
   assign ctrl_o    = ctrl_q;
   assign stat_o    = stat_q;
   assign tag_o     = tag_q;
   assign dptr_o    = dptr_q;
   assign iptr_o    = iptr_q;
   assign opc_o     = opc_q;
   assign stack_o   = stk_q;
   assign cond_o    = {stat_q[14], stat_q[10], stat_q[9], stat_q[8]};
endmodule

// File: rtl/fprs_restore_chk.sv
module fprs_restore_chk #(
   parameter int STK_W   = 640,
   parameter int IMG_LO  = 94,
   parameter int IMG_HI  = 108
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             op32_i,
   input logic             lock_i,
   input logic             emul_i,
   input logic             task_sw_i,
   input logic             busy_o,
   input logic             mem_req_o,
   input logic             done_o,
   input logic [1:0]       fault_o,
   input logic             fp_exc_o,
   input logic [15:0]      ctrl_o,
   input logic [15:0]      stat_o,
   input logic [STK_W-1:0] stack_o
);
   logic [15:0] req_cnt;
   logic        op32_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_cnt <= '0;
         op32_l  <= 1'b0;
      end else if (start_i && !busy_o) begin
         req_cnt <= '0;
         op32_l  <= op32_i;
      end else if (mem_req_o) begin
         req_cnt <= req_cnt + 1'b1;
      end
   end

   assert_one_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o);

   assert_img_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o == 2'd0) |-> (req_cnt == (op32_l ? 16'(IMG_HI) : 16'(IMG_LO))));

   assert_fault_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o != 2'd0) |-> (req_cnt == 16'd0));

   assert_lock_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && lock_i) |=> (done_o && fault_o == 2'd1));

   assert_nm_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !lock_i && (emul_i || task_sw_i)) |=> (done_o && fault_o == 2'd2));

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(ctrl_o) && $stable(stat_o) && $stable(stack_o)));

   assert_hold_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o != 2'd0) |-> ($stable(ctrl_o) && $stable(stack_o)));

   assert_exc_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fp_exc_o |-> (done_o && fault_o == 2'd0));

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
endmodule

bind fprs_restore fprs_restore_chk #(
   .STK_W  (N_REGS*REG_BYTES*8),
   .IMG_LO (7*2 + N_REGS*REG_BYTES),
   .IMG_HI (7*4 + N_REGS*REG_BYTES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .op32_i    (op32_i),
   .lock_i    (lock_i),
   .emul_i    (emul_i),
   .task_sw_i (task_sw_i),
   .busy_o    (busy_o),
   .mem_req_o (mem_req_o),
   .done_o    (done_o),
   .fault_o   (fault_o),
   .fp_exc_o  (fp_exc_o),
   .ctrl_o    (ctrl_o),
   .stat_o    (stat_o),
   .stack_o   (stack_o)
);

// File: tb/fprs_restore_tb.sv
module fprs_restore_tb_top;
   localparam int STK_W = 640;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_addr_i = '0;
   logic        op32_i = 1'b0;
   logic [1:0]  cpl_i = '0;
   logic        v86_i = 1'b0;
   logic        align_chk_i = 1'b0;
   logic        emul_i = 1'b0;
   logic        task_sw_i = 1'b0;
   logic        lock_i = 1'b0;
   logic        mem_req_o;
   logic [31:0] mem_addr_o;
   logic        mem_rvalid_i = 1'b0;
   logic [7:0]  mem_rdata_i = '0;
   logic        busy_o, done_o, fp_exc_o;
   logic [1:0]  fault_o;
   logic [15:0] ctrl_o, stat_o, tag_o, opc_o;
   logic [31:0] dptr_o, iptr_o;
   logic [3:0]  cond_o;
   logic [STK_W-1:0] stack_o;

   fprs_restore dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .op32_i(op32_i), .cpl_i(cpl_i), .v86_i(v86_i), .align_chk_i(align_chk_i),
      .emul_i(emul_i), .task_sw_i(task_sw_i), .lock_i(lock_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
      .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
      .fp_exc_o(fp_exc_o), .ctrl_o(ctrl_o), .stat_o(stat_o), .tag_o(tag_o),
      .dptr_o(dptr_o), .iptr_o(iptr_o), .opc_o(opc_o), .cond_o(cond_o), .stack_o(stack_o)
   );

   always #10 clk = ~clk;

   int tests = 0;
   int fails = 0;

   logic [7:0]  mem [512];
   int          lat = 0;
   logic [31:0] exp_addr = '0;
   int          nreq = 0;
   int          addr_err = 0;
   int          proto_err = 0;
   bit          pending = 1'b0;
   bit          prev_req = 1'b0;
   int          cnt = 0;
   logic [8:0]  raddr = '0;

   // memory model, evaluated at falling edges
   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid_i = 1'b0;
         if (pending) begin
            if (cnt == 0) begin
               mem_rvalid_i = 1'b1;
               mem_rdata_i  = mem[raddr];
               pending      = 1'b0;
            end else begin
               cnt--;
            end
         end
         if (mem_req_o) begin
            if (pending || prev_req) proto_err++;
            if (mem_addr_o !== exp_addr) addr_err++;
            exp_addr = exp_addr + 1;
            nreq++;
            pending = 1'b1;
            cnt     = lat;
            raddr   = mem_addr_o[8:0];
         end
         prev_req = mem_req_o;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic fill(input int seed);
      for (int i = 0; i < 512; i++) mem[i] = 8'((i*37 + seed*91) ^ (i >> 3));
   endtask

   function automatic logic [79:0] rd_le(input int a, input int n);
      logic [79:0] v = '0;
      for (int i = 0; i < n; i++) v[i*8 +: 8] = mem[(a+i) & 511];
      return v;
   endfunction

   // run one request; results left in r_* globals
   logic [1:0] r_fault;
   bit         r_done;
   int         r_hold_err;
   int         r_early_exc;
   int         r_extra_done;
   logic [15:0] pre_ctrl;
   logic [STK_W-1:0] pre_stk;

   task automatic run(input logic [31:0] base, input bit op32, input logic [1:0] cpl,
                      input bit v86, input bit ac, input bit emul, input bit ts,
                      input bit lock, input int poke_at);
      int n = 0;
      @(negedge clk);
      pre_ctrl = ctrl_o;
      pre_stk  = stack_o;
      exp_addr = base; nreq = 0; addr_err = 0; proto_err = 0;
      r_hold_err = 0; r_early_exc = 0; r_extra_done = 0;
      base_addr_i = base; op32_i = op32; cpl_i = cpl; v86_i = v86;
      align_chk_i = ac; emul_i = emul; task_sw_i = ts; lock_i = lock;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o && n < 3000) begin
         if (ctrl_o !== pre_ctrl || stack_o !== pre_stk) r_hold_err++;
         if (fp_exc_o) r_early_exc++;
         if (poke_at != 0 && n == poke_at) begin
            start_i = 1'b1; lock_i = 1'b1; base_addr_i = 32'h0;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      r_done  = done_o;
      r_fault = fault_o;
      if (!r_done) chk(1'b0, "R1 timeout waiting for done", 0, 1);
   endtask

   task automatic check_ctx(input logic [31:0] base, input bit op32, input string tag);
      int s = op32 ? 4 : 2;
      int b = int'(base);
      logic [15:0] ec = rd_le(b, 2);
      logic [15:0] es = rd_le(b+s, 2);
      logic [79:0] e;
      bit stk_ok = 1'b1;
      chk(r_fault == 2'd0, {"R6 no fault ", tag}, r_fault, 0);
      chk(nreq == 7*s + 80 && addr_err == 0, {"R1 byte count/addresses ", tag}, nreq, 7*s + 80);
      chk(proto_err == 0, {"R10 one request at a time ", tag}, proto_err, 0);
      chk(ctrl_o == ec, {"R2 control ", tag}, ctrl_o, ec);
      chk(stat_o == es, {"R2 status ", tag}, stat_o, es);
      e = rd_le(b+2*s, 2); chk(tag_o == e[15:0], {"R2 tag ", tag}, tag_o, e);
      e = rd_le(b+3*s, s); chk(dptr_o == e[31:0], {"R2 data ptr ", tag}, dptr_o, e);
      e = rd_le(b+4*s, s); chk(iptr_o == e[31:0], {"R2 instr ptr ", tag}, iptr_o, e);
      e = rd_le(b+5*s, 2); chk(opc_o == e[15:0], {"R2 opcode ", tag}, opc_o, e);
      for (int k = 0; k < 8; k++) begin
         e = rd_le(b + 7*s + 10*k, 10);
         if (stack_o[80*k +: 80] !== e) begin
            stk_ok = 1'b0;
            chk(1'b0, {"R3 stack register ", tag}, stack_o[80*k +: 80], e);
         end
      end
      chk(stk_ok, {"R3 stack image ", tag}, 0, 0);
      chk(cond_o == {es[14], es[10], es[9], es[8]}, {"R4 condition bits ", tag},
          cond_o, {es[14], es[10], es[9], es[8]});
      chk(fp_exc_o == (|(es[5:0] & ~ec[5:0])), {"R5 exception at done ", tag},
          fp_exc_o, (|(es[5:0] & ~ec[5:0])));
      chk(r_early_exc == 0, {"R5 no early exception ", tag}, r_early_exc, 0);
      chk(r_hold_err == 0, {"R9 outputs held until commit ", tag}, r_hold_err, 0);
   endtask

   task automatic check_fault(input logic [1:0] code, input string tag);
      chk(r_done && r_fault == code, {tag, " fault code"}, r_fault, code);
      chk(nreq == 0, {tag, " no reads"}, nreq, 0);
      chk(ctrl_o == pre_ctrl && stack_o == pre_stk, {"R9 context kept on fault ", tag}, ctrl_o, pre_ctrl);
      chk(fp_exc_o == 1'b0, {"R5 no exception on fault ", tag}, fp_exc_o, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!busy_o && !done_o && fault_o == 0 && !fp_exc_o && !mem_req_o, "R12 reset control outputs",
          {busy_o, done_o, fault_o, fp_exc_o, mem_req_o}, 0);
      chk(ctrl_o == 0 && stat_o == 0 && tag_o == 0 && dptr_o == 0 && iptr_o == 0 && opc_o == 0
          && stack_o == '0, "R12 reset context", ctrl_o, 0);
   endtask

   task automatic t_restore16;
      fill(3); lat = 0;
      mem[9'h40] = 8'h3F;
      run(32'h40, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      check_ctx(32'h40, 1'b0, "16-bit");
   endtask

   task automatic t_restore32;
      fill(7); lat = 2;
      mem[9'h100] = 8'h3F;
      run(32'h100, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      check_ctx(32'h100, 1'b1, "32-bit");
   endtask

   task automatic t_unmasked;
      fill(11); lat = 1;
      mem[9'h80] = 8'h3E;
      mem[9'h84] = 8'h01;
      run(32'h80, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      check_ctx(32'h80, 1'b1, "unmasked exception");
      chk(fp_exc_o == 1'b1, "R5 unmasked flag raises", fp_exc_o, 1);
   endtask

   task automatic t_lock;
      run(32'h40, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0);
      check_fault(2'd1, "R7 lock");
      run(32'h41, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0);
      check_fault(2'd1, "R7 lock over other traps");
   endtask

   task automatic t_nm;
      run(32'h40, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
      check_fault(2'd2, "R6 emulate");
      run(32'h41, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
      check_fault(2'd2, "R6 task switched over alignment");
   endtask

   task automatic t_align;
      run(32'h41, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      check_fault(2'd3, "R8 misaligned at level 3");
      run(32'h41, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      check_fault(2'd3, "R8 misaligned in v86");
      run(32'h102, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      check_fault(2'd3, "R8 32-bit word-aligned base");
      fill(5); lat = 0;
      run(32'h41, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      check_ctx(32'h41, 1'b0, "R8 misaligned at level 0");
      fill(9);
      run(32'h102, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      check_ctx(32'h102, 1'b0, "R8 16-bit word-aligned base");
      fill(13);
      run(32'h43, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      check_ctx(32'h43, 1'b1, "R8 checking off");
   endtask

   task automatic t_busy_start;
      fill(17); lat = 1;
      run(32'h180, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 40);
      check_ctx(32'h180, 1'b1, "R11 start while busy");
      lock_i = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (done_o || busy_o) r_extra_done++;
      end
      chk(r_extra_done == 0, "R11 no extra done after ignored start", r_extra_done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      fill(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_restore16();
      t_lock();
      t_restore32();
      t_nm();
      t_unmasked();
      t_align();
      t_busy_start();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule